// File: doc/BRIEF.md
# Two-Lane Interleaved Sequential Multiplier

This block multiplies two unsigned operands and accepts a new request more often than a single sequential shift-and-add multiplier could. It contains two identical multiplier lanes, each of which takes one cycle per operand bit. A steering stage registers each one-cycle request strobe together with its operands. It hands the request to the two lanes in turn. A merge stage picks the product of whichever lane has just finished, registers it, and raises one shared one-cycle ready pulse.

The requester raises `new_i` for one cycle with both operands valid in that cycle. The product and `ready_o` come back a fixed number of cycles later. With the default 8-bit operands, the block keeps up with one request every 4 cycles. Requests spaced closer than that are not supported, and the block does not queue them.

Top module: `dual_lane_mult`

## Requirements
- R1: While `rst_n` is low at a rising edge, `ready_o` and `product_o` go to 0 on that edge. The lane selector also returns to lane 0, so the first request after reset always goes to lane 0.
- R2: The value of `product_o` delivered with `ready_o` equals the unsigned product `opa_i * opb_i` of the operands sampled together with the strobe. This includes the corners 0, 1 and the all-ones operand.
- R3: For each accepted strobe, `ready_o` is high for exactly one cycle. The rising edge that sets it is the (OP_W+2)-th rising edge after the edge that sampled `new_i` high, which is the 10th edge at the default width. Without strobes, `ready_o` is never raised.
- R4: Accepted strobes are given to lane 0 and lane 1 alternately, with exactly one lane started per strobe. Because of this, requests spaced 4 cycles apart all complete correctly and in request order.
- R5: Between ready pulses, `product_o` holds the last delivered product.
- R6: Operands are sampled only at the edge where `new_i` is high. Changing `opa_i` or `opb_i` at any other time has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| new_i | input | 1 | One-cycle request strobe |
| opa_i | input | OP_W (8) | Multiplicand, unsigned |
| opb_i | input | OP_W (8) | Multiplier, unsigned |
| product_o | output | 2*OP_W (16) | Registered product, held between results |
| ready_o | output | 1 | One-cycle pulse marking a new product |

## Verification
The block is exercised with several input patterns, each separating a different fault:
- Isolated requests with corner operands (zero, one, all-ones, a single high bit) expose errors in the add and shift paths and in the last-step timing.
- A stream of requests spaced four cycles apart only completes correctly if the steering really alternates between the lanes. It also checks that the merge stage returns results in request order.
- Operands that change while the lanes are busy catch any lane that reads its inputs after the strobe cycle.
- A reset in the middle of a computation shows that pending results are discarded and that the first request afterwards is delivered normally.

// File: rtl/dlm_pkg.sv
// Package: shared types for the two-lane multiplier.
// Assumes exactly two lanes; the lane index is a single bit.
package dlm_pkg;
    typedef enum logic {LANE_0 = 1'b0, LANE_1 = 1'b1} lane_e;

    localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/dlm_steer.sv
// Module: dlm_steer
// Registers each request strobe and its operands and starts one lane per
// strobe, alternating. Assumes strobes are one cycle wide. The outputs come
// straight from flops so that the lanes see clean registered starts.
module dlm_steer #(
    parameter int unsigned OP_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           new_i,
    input  logic [OP_W-1:0]                opa_i,
    input  logic [OP_W-1:0]                opb_i,
    output logic [dlm_pkg::NUM_LANES-1:0]  start_o,
    output logic [OP_W-1:0]                opa_o,
    output logic [OP_W-1:0]                opb_o
);
    import dlm_pkg::*;

    lane_e next_lane;

    // Purpose: flip the lane pointer on each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_lane <= LANE_0;
        end else if (new_i) begin
            next_lane <= (next_lane == LANE_0) ? LANE_1 : LANE_0;
        end
    end

    // Purpose: issue a registered one-cycle start to the selected lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= '0;
        end else begin
            start_o    <= '0;
            start_o[0] <= new_i && (next_lane == LANE_0);
            start_o[1] <= new_i && (next_lane == LANE_1);
        end
    end

    // Purpose: keep a copy of the operands that goes with the start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_o <= '0;
            opb_o <= '0;
        end else if (new_i) begin
            opa_o <= opa_i;
            opb_o <= opb_i;
        end
    end
endmodule

// File: rtl/dlm_lane.sv
// Module: dlm_lane
// Unsigned shift-and-add multiplier that handles one multiplier bit per cycle.
// Operands are captured on the start edge. After OP_W steps, done_o pulses
// for one cycle and prod_o holds the result until the next completion.
// A start may arrive on the same edge as the final step; both take effect.
module dlm_lane #(
    parameter int unsigned OP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    output logic              done_o,
    output logic [2*OP_W-1:0] prod_o
);
    localparam int unsigned PROD_W = 2 * OP_W;
    localparam int unsigned CNT_W  = (OP_W > 1) ? $clog2(OP_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(OP_W - 1);

    logic [PROD_W-1:0] mcand;
    logic [OP_W-1:0]   mplier;
    logic [PROD_W-1:0] acc;
    logic [PROD_W-1:0] acc_next;
    logic [CNT_W-1:0]  step;
    logic              busy;

    // Purpose: add the shifted multiplicand when the current multiplier bit is 1.
    always_comb begin
        acc_next = mplier[0] ? (acc + mcand) : acc;
    end

    // Purpose: step the datapath, finish after the last step, load on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            step   <= '0;
            busy   <= 1'b0;
            done_o <= 1'b0;
            prod_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (busy) begin
                acc    <= acc_next;
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                step   <= step + 1'b1;
                if (step == LAST_STEP) begin
                    busy   <= 1'b0;
                    done_o <= 1'b1;
                    prod_o <= acc_next;
                end
            end
            if (start_i) begin
                mcand  <= {{OP_W{1'b0}}, opa_i};
                mplier <= opb_i;
                acc    <= '0;
                step   <= '0;
                busy   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dlm_merge.sv
// Module: dlm_merge
// Picks the product of the lane that has just finished and registers it
// together with a shared one-cycle ready. Assumes at most one lane finishes
// in any cycle; if two did, the lowest index would win.
module dlm_merge #(
    parameter int unsigned OP_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [dlm_pkg::NUM_LANES-1:0]  done_i,
    input  logic [2*OP_W-1:0]              prod_i [dlm_pkg::NUM_LANES],
    output logic                           ready_o,
    output logic [2*OP_W-1:0]              product_o
);
    import dlm_pkg::*;

    localparam int unsigned PROD_W = 2 * OP_W;

    logic [PROD_W-1:0] pick;
    logic              any_done;

    // Purpose: choose the finishing lane, lowest index first.
    always_comb begin
        pick     = '0;
        any_done = 1'b0;
        for (int i = NUM_LANES - 1; i >= 0; i--) begin
            if (done_i[i]) begin
                pick     = prod_i[i];
                any_done = 1'b1;
            end
        end
    end

    // Purpose: register the ready pulse and update the held product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_o   <= 1'b0;
            product_o <= '0;
        end else begin
            ready_o <= any_done;
            if (any_done) begin
                product_o <= pick;
            end
        end
    end
endmodule

// File: rtl/dual_lane_mult.sv
// Module: dual_lane_mult (top)
// Two sequential multiplier lanes fed alternately by a steering stage and
// merged onto one output. Result latency is OP_W+2 edges after the sampling
// edge. Assumes request strobes are at least OP_W/2 cycles apart.
module dual_lane_mult #(
    parameter int unsigned OP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_i,
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    output logic [2*OP_W-1:0] product_o,
    output logic              ready_o
);
    import dlm_pkg::*;

    localparam int unsigned PROD_W = 2 * OP_W;

    logic [NUM_LANES-1:0] lane_start;
    logic [NUM_LANES-1:0] lane_done;
    logic [PROD_W-1:0]    lane_prod [NUM_LANES];
    logic [OP_W-1:0]      opa_q;
    logic [OP_W-1:0]      opb_q;

    dlm_steer #(.OP_W(OP_W)) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .new_i   (new_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .start_o (lane_start),
        .opa_o   (opa_q),
        .opb_o   (opb_q)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dlm_lane #(.OP_W(OP_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (lane_start[g]),
            .opa_i   (opa_q),
            .opb_i   (opb_q),
            .done_o  (lane_done[g]),
            .prod_o  (lane_prod[g])
        );
    end

    dlm_merge #(.OP_W(OP_W)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (lane_done),
        .prod_i    (lane_prod),
        .ready_o   (ready_o),
        .product_o (product_o)
    );
endmodule

// File: rtl/dlm_checker.sv
// Module: dlm_checker
// Property checks for dual_lane_mult, attached with bind. Tracks the
// expected next lane in its own flop. Assumes strobes at least 2 cycles apart.
module dlm_checker #(
    parameter int unsigned OP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              new_i,
    input logic [1:0]        lane_start,
    input logic [1:0]        lane_done,
    input logic              ready_o,
    input logic [2*OP_W-1:0] product_o
);
    logic expect_lane1;

    // Purpose: model which lane the next strobe must start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_lane1 <= 1'b0;
        end else if (lane_start[0]) begin
            expect_lane1 <= 1'b1;
        end else if (lane_start[1]) begin
            expect_lane1 <= 1'b0;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!ready_o && product_o == '0)); // R1

    AST_ONE_LANE_PER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        new_i |=> $countones(lane_start) == 1); // R4

    AST_LANE0_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        lane_start[0] |-> !expect_lane1); // R4

    AST_LANE1_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        lane_start[1] |-> expect_lane1); // R4

    AST_SINGLE_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_done)); // R3

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o); // R3

    AST_HOLD_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> $stable(product_o)); // R5
endmodule

bind dual_lane_mult dlm_checker #(.OP_W(OP_W)) u_dlm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .new_i      (new_i),
    .lane_start (lane_start),
    .lane_done  (lane_done),
    .ready_o    (ready_o),
    .product_o  (product_o)
);

// File: tb/tb_dual_lane_mult.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (queue of due cycle and product),
// compared with the outputs at every falling edge.
module tb_dual_lane_mult;
    localparam int unsigned OP_W   = 8;
    localparam int unsigned PROD_W = 2 * OP_W;
    // strobe driven after falling edge n -> first visible at falling edge n+OP_W+3
    localparam int DUE_OFS = OP_W + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              new_i = 1'b0;
    logic [OP_W-1:0]   opa_i = '0;
    logic [OP_W-1:0]   opb_i = '0;
    logic [PROD_W-1:0] product_o;
    logic              ready_o;

    int unsigned       tests = 0;
    int unsigned       fails = 0;
    int                cyc = 0;
    int                due_q[$];
    logic [PROD_W-1:0] val_q[$];
    logic [PROD_W-1:0] exp_prod = '0;
    string             tag = "R1";
    bit                finished = 1'b0;

    always #10 clk = ~clk;

    dual_lane_mult #(.OP_W(OP_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_i     (new_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .product_o (product_o),
        .ready_o   (ready_o)
    );

    // Compare the outputs with the reference model at this falling edge.
    task automatic check_outputs();
        logic exp_ready;
        exp_ready = (due_q.size() > 0) && (due_q[0] == cyc);
        tests++;
        if (ready_o !== exp_ready) begin
            fails++;
            $display("FAIL R3 (%s) cycle %0d: ready_o=%b expected %b", tag, cyc, ready_o, exp_ready);
        end
        if (exp_ready) begin
            void'(due_q.pop_front());
            exp_prod = val_q.pop_front();
            tests++;
            if (product_o !== exp_prod) begin
                fails++;
                $display("FAIL %s cycle %0d: product_o=%0d expected %0d", tag, cyc, product_o, exp_prod);
            end
        end else begin
            tests++;
            if (product_o !== exp_prod) begin
                fails++;
                $display("FAIL R5 (%s) cycle %0d: product_o=%0d expected held %0d", tag, cyc, product_o, exp_prod);
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        check_outputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // One-cycle request; the expected result is queued for its due cycle.
    task automatic request(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        new_i = 1'b1;
        opa_i = a;
        opb_i = b;
        due_q.push_back(cyc + DUE_OFS);
        val_q.push_back(PROD_W'(a) * PROD_W'(b));
        tick();
        new_i = 1'b0;
    endtask

    task automatic apply_reset(input int n);
        rst_n = 1'b0;
        due_q.delete();
        val_q.delete();
        exp_prod = '0;
        idle(n);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        apply_reset(3);
        idle(4);

        // R2: isolated requests with corner operands
        tag = "R2";
        request(8'd0, 8'd0);     idle(12);
        request(8'd255, 8'd255); idle(12);
        request(8'd1, 8'd255);   idle(12);
        request(8'd128, 8'd2);   idle(12);
        request(8'd0, 8'd77);    idle(12);
        request(8'd13, 8'd11);   idle(12);

        // R4: back-to-back stream at 4-cycle spacing, alternating lanes
        tag = "R4";
        for (int i = 0; i < 12; i++) begin
            request(8'((i * 37 + 5) & 255), 8'((i * 91 + 200) & 255));
            idle(3);
        end
        idle(14);

        // R6: operands wiggle while lanes compute; no strobes -> no ready
        tag = "R6";
        request(8'd201, 8'd99);
        for (int i = 0; i < 6; i++) begin
            opa_i = 8'(i * 53 + 7);
            opb_i = 8'(i * 29 + 250);
            tick();
        end
        request(8'd45, 8'd3);
        for (int i = 0; i < 14; i++) begin
            opa_i = 8'(i * 17 + 1);
            opb_i = 8'(255 - i);
            tick();
        end
        idle(10);

        // R1: reset in mid computation drops pending work, then restart
        tag = "R1";
        request(8'd77, 8'd66);
        idle(2);
        request(8'd9, 8'd9);
        idle(2);
        apply_reset(2);
        idle(12);
        request(8'd250, 8'd251);
        idle(3);
        request(8'd3, 8'd5);
        idle(14);

        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end
endmodule